// File: doc/BRIEF.md
# Serial Link Controller Register Bank

This block is the byte-wide control and status register bank of a multi-node serial link controller. A host reaches it through a memory-mapped port with a 5-bit address, a chip select and separate read and write strobes. There is no wait state: read data is valid in the same cycle as the read strobe, and a write takes effect at the clock edge that ends the write cycle. The bank holds the line configuration, which covers the operating mode, timing windows, the address filter and the two baud dividers. It drives each of these values directly to the datapath.

The datapath reports events as single-cycle pulses, and these set sticky bits in an interrupt flag byte. The datapath also reports three live conditions, which appear in the same byte without being stored. Reading the flag byte clears only the sticky bits. A mask byte selects which flags raise the interrupt line. The receive and transmit command addresses accept write-only bits, and each set bit becomes a one-cycle pulse that tells the datapath to switch a page, rewind a pointer, reset or abort. The two data-port addresses pass each strobe straight through to the page memories, which sit outside this block, so a burst of back-to-back accesses moves one byte per cycle.

Top module: `node_csr_bank`

## Requirements
- R1: After reset the bank reads as follows: 0x00 = 0x0e (version), 0x02 = 0x10 (setting), 0x04 = 0x0a (idle wait), 0x05/0x06 = 0x14/0x00 (10-bit permit time), 0x07/0x08 = 0xc8/0x00 (10-bit max idle), 0x09 = 0x01 (2-bit pre-enable length), 0x0b = 0xff (local address filter), 0x1a and 0x1b = 0xff (group filters), 0x0c/0x0d and 0x0e/0x0f = 0x5a/0x01 (dividers, low byte first), 0x11 = 0x00 (mask). The irq output is low.
- R2: A write with sel high updates the addressed configuration register. The register reads back the new value at once and drives it on its cfg_* output from the next cycle. High bytes of 10-bit fields keep only bits 1:0, the pre-enable length keeps bits 1:0, and setting bit 7 reads as 0. A write with sel low changes nothing, and a write to the version address has no effect.
- R3: cfg_mode decodes setting bits 6:4 as follows: 001 gives 1 (arbitration), 010 gives 2 (break-sync), 100 gives 3 (full duplex), and 000 gives 0 (plain half duplex). Every other pattern also gives 0.
- R4: Each event pulse sets its flag bit at the next edge: tx error sets bit 7, collision bit 6, rx frame error bit 4, rx lost bit 3 and break received bit 2. The bit then stays set until the flag register is read.
- R5: A read of the flag register at 0x10 returns the flag value that was current before the read. It clears bits 7, 6, 4, 3 and 2 at the edge that ends the read.
- R6: Flag bits 5 (tx page free), 1 (rx page ready) and 0 (bus idle) follow their status inputs in the same cycle, and a flag read leaves them unchanged.
- R7: An event pulse that arrives in the same cycle as a clearing flag read leaves its bit set after that read.
- R8: The mask register sits at 0x11. irq is high exactly when the flag byte ANDed with the mask byte is non-zero.
- R9: A write to 0x16 produces a one-cycle pulse in the cycle after the write for each set bit: bit 4 on cmd_rx_reset, bit 1 on cmd_rx_switch and bit 0 on cmd_rx_rewind. Reading 0x16 returns 0.
- R10: A write to 0x17 produces a one-cycle pulse in the cycle after the write for each set bit: bit 5 on cmd_tx_break, bit 4 on cmd_tx_abort, bit 1 on cmd_tx_switch and bit 0 on cmd_tx_rewind. Reading 0x17 returns 0.
- R11: During a read of 0x14, rdata equals rx_port_data and rx_pop is high in that same cycle. During a write to 0x15, tx_push is high and tx_push_data equals wdata. Each cycle of a burst counts as one access.
- R12: A read of any unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select for the register port |
| addr | input | 5 | Register address |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| irq | output | 1 | Interrupt request |
| ev_tx_err | input | 1 | Pulse: transmitted 0 read back as 1 |
| ev_collide | input | 1 | Pulse: collision detected |
| ev_rx_broken | input | 1 | Pulse: received frame broken |
| ev_rx_lost | input | 1 | Pulse: no free receive page |
| ev_brk_seen | input | 1 | Pulse: break character received |
| st_tx_free | input | 1 | Level: transmit page released |
| st_rx_ready | input | 1 | Level: receive page ready |
| st_idle | input | 1 | Level: bus idle |
| rx_port_data | input | 8 | Byte from the receive page |
| rx_pop | output | 1 | Receive data-port read strobe |
| tx_push | output | 1 | Transmit data-port write strobe |
| tx_push_data | output | 8 | Byte for the transmit page |
| cmd_rx_reset | output | 1 | Pulse: reset receive logic |
| cmd_rx_switch | output | 1 | Pulse: switch receive page |
| cmd_rx_rewind | output | 1 | Pulse: rewind receive read pointer |
| cmd_tx_break | output | 1 | Pulse: send break |
| cmd_tx_abort | output | 1 | Pulse: abort transmission |
| cmd_tx_switch | output | 1 | Pulse: switch transmit page |
| cmd_tx_rewind | output | 1 | Pulse: rewind transmit write pointer |
| cfg_setting | output | 8 | Setting byte |
| cfg_mode | output | 2 | Decoded link mode |
| cfg_idle_wait | output | 8 | Idle wait length |
| cfg_permit | output | 10 | Transmit permit length |
| cfg_max_idle | output | 10 | Max idle length |
| cfg_pre_len | output | 2 | Driver pre-enable length |
| cfg_filter | output | 8 | Local address filter |
| cfg_mcast0 | output | 8 | Group filter 0 |
| cfg_mcast1 | output | 8 | Group filter 1 |
| cfg_div_ls | output | 16 | Low-speed divider |
| cfg_div_hs | output | 16 | High-speed divider |

## Verification
The flag logic gets four stimulus patterns. An isolated event pulse, followed by two reads, separates the sticky behaviour from the clear-on-read behaviour. Live status levels, read twice, show that those bits are not cleared. An event timed onto the exact cycle of a clearing read shows whether the design loses that event. Command writes with different bit patterns show whether each bit drives its own pulse for exactly one cycle, and setting patterns, including one with two bits set, cover every branch of the mode decode.

// File: rtl/node_csr_pkg.sv
package node_csr_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_VERSION = 5'h00;
  localparam logic [ADDR_W-1:0] A_SETTING = 5'h02;
  localparam logic [ADDR_W-1:0] A_IDLE    = 5'h04;
  localparam logic [ADDR_W-1:0] A_PERM_L  = 5'h05;
  localparam logic [ADDR_W-1:0] A_PERM_H  = 5'h06;
  localparam logic [ADDR_W-1:0] A_MAXI_L  = 5'h07;
  localparam logic [ADDR_W-1:0] A_MAXI_H  = 5'h08;
  localparam logic [ADDR_W-1:0] A_PRE     = 5'h09;
  localparam logic [ADDR_W-1:0] A_FILT    = 5'h0b;
  localparam logic [ADDR_W-1:0] A_DLS_L   = 5'h0c;
  localparam logic [ADDR_W-1:0] A_DLS_H   = 5'h0d;
  localparam logic [ADDR_W-1:0] A_DHS_L   = 5'h0e;
  localparam logic [ADDR_W-1:0] A_DHS_H   = 5'h0f;
  localparam logic [ADDR_W-1:0] A_FLAG    = 5'h10;
  localparam logic [ADDR_W-1:0] A_MASK    = 5'h11;
  localparam logic [ADDR_W-1:0] A_RXD     = 5'h14;
  localparam logic [ADDR_W-1:0] A_TXD     = 5'h15;
  localparam logic [ADDR_W-1:0] A_RXC     = 5'h16;
  localparam logic [ADDR_W-1:0] A_TXC     = 5'h17;
  localparam logic [ADDR_W-1:0] A_FM0     = 5'h1a;
  localparam logic [ADDR_W-1:0] A_FM1     = 5'h1b;

  // flag bits cleared by a read, and bits that mirror live status
  localparam logic [DATA_W-1:0] STICKY_MASK = 8'b1101_1100;
  localparam logic [DATA_W-1:0] LIVE_MASK   = 8'b0010_0011;

  typedef enum logic [1:0] {
    MODE_HALF  = 2'd0,
    MODE_ARB   = 2'd1,
    MODE_BSYNC = 2'd2,
    MODE_FULL  = 2'd3
  } link_mode_e;

  function automatic logic [DATA_W-1:0] f_flag_next(
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] set,
      input logic              clr);
    logic [DATA_W-1:0] kept;
    kept = clr ? (cur & ~STICKY_MASK) : cur;
    return kept | (set & STICKY_MASK);
  endfunction

  function automatic link_mode_e f_mode(input logic [2:0] sel_bits);
    case (sel_bits)
      3'b001:  return MODE_ARB;
      3'b010:  return MODE_BSYNC;
      3'b100:  return MODE_FULL;
      default: return MODE_HALF;
    endcase
  endfunction

  function automatic logic f_irq(input logic [DATA_W-1:0] flags,
                                 input logic [DATA_W-1:0] mask);
    return |(flags & mask);
  endfunction
endpackage

// File: rtl/csr_split_reg.sv
module csr_split_reg #(
  parameter int                       W    = 16,
  parameter logic [W-1:0]             DEF  = '0,
  parameter logic [4:0]               A_LO = 5'h0,
  parameter logic [4:0]               A_HI = 5'h1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [4:0]   addr,
  input  logic [7:0]   wdata,
  output logic [W-1:0] val,
  output logic         rd_hit,
  output logic [7:0]   rd_val
);
  localparam int HW = W - 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= DEF;
    end else if (wr_en && addr == A_LO) begin
      val[7:0] <= wdata;
    end else if (wr_en && addr == A_HI) begin
      val[W-1:8] <= HW'(wdata);
    end
  end

  always_comb begin
    rd_hit = (addr == A_LO) || (addr == A_HI);
    if (addr == A_LO) rd_val = val[7:0];
    else if (addr == A_HI) rd_val = 8'(val >> 8);
    else rd_val = 8'h00;
  end
endmodule

// File: rtl/csr_cfg_bank.sv
module csr_cfg_bank
  import node_csr_pkg::*;
#(
  parameter int              TIME_W       = 10,
  parameter int              DIV_W        = 16,
  parameter logic [DIV_W-1:0]  DEF_DIV_LS   = 16'h015a,
  parameter logic [DIV_W-1:0]  DEF_DIV_HS   = 16'h015a,
  parameter logic [TIME_W-1:0] DEF_PERMIT   = 10'h014,
  parameter logic [TIME_W-1:0] DEF_MAX_IDLE = 10'h0c8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [7:0]        setting,
  output logic [7:0]        idle_wait,
  output logic [TIME_W-1:0] permit,
  output logic [TIME_W-1:0] max_idle,
  output logic [1:0]        pre_len,
  output logic [7:0]        filt,
  output logic [7:0]        fm0,
  output logic [7:0]        fm1,
  output logic [DIV_W-1:0]  div_ls,
  output logic [DIV_W-1:0]  div_hs,
  output logic              rd_hit,
  output logic [7:0]        rd_val
);
  logic [3:0] sp_hit;
  logic [7:0] sp_val [4];

  csr_split_reg #(.W(TIME_W), .DEF(DEF_PERMIT), .A_LO(A_PERM_L), .A_HI(A_PERM_H)) u_permit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .val(permit), .rd_hit(sp_hit[0]), .rd_val(sp_val[0]));
  csr_split_reg #(.W(TIME_W), .DEF(DEF_MAX_IDLE), .A_LO(A_MAXI_L), .A_HI(A_MAXI_H)) u_maxidle (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .val(max_idle), .rd_hit(sp_hit[1]), .rd_val(sp_val[1]));
  csr_split_reg #(.W(DIV_W), .DEF(DEF_DIV_LS), .A_LO(A_DLS_L), .A_HI(A_DLS_H)) u_div_ls (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .val(div_ls), .rd_hit(sp_hit[2]), .rd_val(sp_val[2]));
  csr_split_reg #(.W(DIV_W), .DEF(DEF_DIV_HS), .A_LO(A_DHS_L), .A_HI(A_DHS_H)) u_div_hs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .val(div_hs), .rd_hit(sp_hit[3]), .rd_val(sp_val[3]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setting   <= 8'h10;
      idle_wait <= 8'h0a;
      pre_len   <= 2'd1;
      filt      <= 8'hff;
      fm0       <= 8'hff;
      fm1       <= 8'hff;
    end else if (wr_en) begin
      case (addr)
        A_SETTING: setting   <= wdata & 8'h7f;
        A_IDLE:    idle_wait <= wdata;
        A_PRE:     pre_len   <= 2'(wdata);
        A_FILT:    filt      <= wdata;
        A_FM0:     fm0       <= wdata;
        A_FM1:     fm1       <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_hit = 1'b1;
    rd_val = 8'h00;
    case (addr)
      A_SETTING: rd_val = setting;
      A_IDLE:    rd_val = idle_wait;
      A_PRE:     rd_val = {6'd0, pre_len};
      A_FILT:    rd_val = filt;
      A_FM0:     rd_val = fm0;
      A_FM1:     rd_val = fm1;
      default: begin
        rd_hit = |sp_hit;
        for (int i = 0; i < 4; i++) rd_val = rd_val | sp_val[i];
      end
    endcase
  end
endmodule

// File: rtl/csr_flag_unit.sv
module csr_flag_unit
  import node_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ev_set,
  input  logic [DATA_W-1:0] live,
  input  logic              clr_rd,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] mask,
  output logic              irq
);
  logic [DATA_W-1:0] sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask     <= '0;
    end else begin
      sticky_q <= f_flag_next(sticky_q, ev_set, clr_rd);
      if (mask_wr) mask <= wdata;
    end
  end

  assign flags = sticky_q | (live & LIVE_MASK);
  assign irq   = f_irq(flags, mask);
endmodule

// File: rtl/csr_cmd_unit.sv
module csr_cmd_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxc_wr,
  input  logic       txc_wr,
  input  logic [2:0] rx_bits,
  input  logic [3:0] tx_bits,
  output logic [2:0] rx_pulse,
  output logic [3:0] tx_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pulse <= '0;
      tx_pulse <= '0;
    end else begin
      rx_pulse <= rxc_wr ? rx_bits : 3'd0;
      tx_pulse <= txc_wr ? tx_bits : 4'd0;
    end
  end
endmodule

// File: rtl/node_csr_bank.sv
module node_csr_bank
  import node_csr_pkg::*;
#(
  parameter logic [7:0]        VERSION      = 8'h0e,
  parameter int                TIME_W       = 10,
  parameter int                DIV_W        = 16,
  parameter logic [DIV_W-1:0]  DEF_DIV_LS   = 16'h015a,
  parameter logic [DIV_W-1:0]  DEF_DIV_HS   = 16'h015a,
  parameter logic [TIME_W-1:0] DEF_PERMIT   = 10'h014,
  parameter logic [TIME_W-1:0] DEF_MAX_IDLE = 10'h0c8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [4:0]        addr,
  input  logic              rd,
  output logic [7:0]        rdata,
  input  logic              wr,
  input  logic [7:0]        wdata,
  output logic              irq,
  input  logic              ev_tx_err,
  input  logic              ev_collide,
  input  logic              ev_rx_broken,
  input  logic              ev_rx_lost,
  input  logic              ev_brk_seen,
  input  logic              st_tx_free,
  input  logic              st_rx_ready,
  input  logic              st_idle,
  input  logic [7:0]        rx_port_data,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [7:0]        tx_push_data,
  output logic              cmd_rx_reset,
  output logic              cmd_rx_switch,
  output logic              cmd_rx_rewind,
  output logic              cmd_tx_break,
  output logic              cmd_tx_abort,
  output logic              cmd_tx_switch,
  output logic              cmd_tx_rewind,
  output logic [7:0]        cfg_setting,
  output logic [1:0]        cfg_mode,
  output logic [7:0]        cfg_idle_wait,
  output logic [TIME_W-1:0] cfg_permit,
  output logic [TIME_W-1:0] cfg_max_idle,
  output logic [1:0]        cfg_pre_len,
  output logic [7:0]        cfg_filter,
  output logic [7:0]        cfg_mcast0,
  output logic [7:0]        cfg_mcast1,
  output logic [DIV_W-1:0]  cfg_div_ls,
  output logic [DIV_W-1:0]  cfg_div_hs
);
  logic       wr_en, rd_en;
  logic       flag_clr_rd;
  logic [7:0] flag_view, mask_view;
  logic [7:0] ev_vec, live_vec;
  logic       cfg_hit;
  logic [7:0] cfg_val;
  logic [2:0] rx_pulse;
  logic [3:0] tx_pulse;

  assign wr_en       = sel && wr;
  assign rd_en       = sel && rd;
  assign flag_clr_rd = rd_en && (addr == A_FLAG);

  assign ev_vec   = {ev_tx_err, ev_collide, 1'b0, ev_rx_broken, ev_rx_lost, ev_brk_seen, 2'b00};
  assign live_vec = {2'b00, st_tx_free, 3'b000, st_rx_ready, st_idle};

  csr_cfg_bank #(
    .TIME_W(TIME_W), .DIV_W(DIV_W), .DEF_DIV_LS(DEF_DIV_LS), .DEF_DIV_HS(DEF_DIV_HS),
    .DEF_PERMIT(DEF_PERMIT), .DEF_MAX_IDLE(DEF_MAX_IDLE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .setting(cfg_setting), .idle_wait(cfg_idle_wait), .permit(cfg_permit),
    .max_idle(cfg_max_idle), .pre_len(cfg_pre_len), .filt(cfg_filter),
    .fm0(cfg_mcast0), .fm1(cfg_mcast1), .div_ls(cfg_div_ls), .div_hs(cfg_div_hs),
    .rd_hit(cfg_hit), .rd_val(cfg_val));

  csr_flag_unit u_flag (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_vec), .live(live_vec),
    .clr_rd(flag_clr_rd), .mask_wr(wr_en && addr == A_MASK), .wdata(wdata),
    .flags(flag_view), .mask(mask_view), .irq(irq));

  csr_cmd_unit u_cmd (
    .clk(clk), .rst_n(rst_n),
    .rxc_wr(wr_en && addr == A_RXC), .txc_wr(wr_en && addr == A_TXC),
    .rx_bits({wdata[4], wdata[1], wdata[0]}),
    .tx_bits({wdata[5], wdata[4], wdata[1], wdata[0]}),
    .rx_pulse(rx_pulse), .tx_pulse(tx_pulse));

  assign {cmd_rx_reset, cmd_rx_switch, cmd_rx_rewind} = rx_pulse;
  assign {cmd_tx_break, cmd_tx_abort, cmd_tx_switch, cmd_tx_rewind} = tx_pulse;
  assign cfg_mode = 2'(f_mode(cfg_setting[6:4]));

  assign rx_pop       = rd_en && (addr == A_RXD);
  assign tx_push      = wr_en && (addr == A_TXD);
  assign tx_push_data = wdata;

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      case (addr)
        A_VERSION: rdata = VERSION;
        A_FLAG:    rdata = flag_view;
        A_MASK:    rdata = mask_view;
        A_RXD:     rdata = rx_port_data;
        default:   rdata = cfg_hit ? cfg_val : 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/node_csr_bank_chk.sv
module node_csr_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr,
  input logic [4:0] addr,
  input logic [7:0] wdata,
  input logic       irq,
  input logic       ev_brk_seen,
  input logic [7:0] flag_view,
  input logic       flag_clr_rd,
  input logic       cmd_rx_switch,
  input logic       cmd_tx_break
);
  AST_RX_SWITCH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rx_switch |-> $past(sel && wr && addr == 5'h16 && wdata[1])); // R9
  AST_TX_BREAK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_break |-> $past(sel && wr && addr == 5'h17 && wdata[5])); // R10
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_view[7] && !flag_clr_rd) |=> flag_view[7]); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_rd && !ev_brk_seen) |=> !flag_view[2]); // R5
  AST_RACE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_rd && ev_brk_seen) |=> flag_view[2]); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_view == 8'h00) |-> !irq); // R8
endmodule

bind node_csr_bank node_csr_bank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
  .irq(irq), .ev_brk_seen(ev_brk_seen), .flag_view(flag_view),
  .flag_clr_rd(flag_clr_rd), .cmd_rx_switch(cmd_rx_switch), .cmd_tx_break(cmd_tx_break));

// File: tb/node_csr_bank_tb_top.sv
`timescale 1ns/1ps
module node_csr_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 0, rd = 0, wr = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  logic ev_tx_err = 0, ev_collide = 0, ev_rx_broken = 0, ev_rx_lost = 0, ev_brk_seen = 0;
  logic st_tx_free = 0, st_rx_ready = 0, st_idle = 0;
  logic [7:0] rx_port_data = '0, tx_push_data;
  logic rx_pop, tx_push;
  logic cmd_rx_reset, cmd_rx_switch, cmd_rx_rewind;
  logic cmd_tx_break, cmd_tx_abort, cmd_tx_switch, cmd_tx_rewind;
  logic [7:0] cfg_setting, cfg_idle_wait, cfg_filter, cfg_mcast0, cfg_mcast1;
  logic [1:0] cfg_mode, cfg_pre_len;
  logic [9:0] cfg_permit, cfg_max_idle;
  logic [15:0] cfg_div_ls, cfg_div_hs;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  node_csr_bank dut_i (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    sel = 0; rd = 0;
  endtask

  task automatic read_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_read(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    read_chk("R1 version", 5'h00, 8'h0e);
    read_chk("R1 setting", 5'h02, 8'h10);
    read_chk("R1 idle", 5'h04, 8'h0a);
    read_chk("R1 permit lo", 5'h05, 8'h14);
    read_chk("R1 permit hi", 5'h06, 8'h00);
    read_chk("R1 maxidle lo", 5'h07, 8'hc8);
    read_chk("R1 maxidle hi", 5'h08, 8'h00);
    read_chk("R1 prelen", 5'h09, 8'h01);
    read_chk("R1 filter", 5'h0b, 8'hff);
    read_chk("R1 div ls lo", 5'h0c, 8'h5a);
    read_chk("R1 div ls hi", 5'h0d, 8'h01);
    read_chk("R1 div hs lo", 5'h0e, 8'h5a);
    read_chk("R1 div hs hi", 5'h0f, 8'h01);
    read_chk("R1 mask", 5'h11, 8'h00);
    read_chk("R1 mcast0", 5'h1a, 8'hff);
    read_chk("R1 mcast1", 5'h1b, 8'hff);
  endtask

  task automatic t_config;
    bus_write(5'h0c, 8'h02); bus_write(5'h0d, 8'h00);
    chk("R2 div_ls out", cfg_div_ls, 16'h0002);
    bus_write(5'h0f, 8'hab);
    chk("R2 div_hs out", cfg_div_hs, 16'hab5a);
    bus_write(5'h06, 8'hff);
    read_chk("R2 permit hi masked", 5'h06, 8'h03);
    chk("R2 permit out", cfg_permit, 10'h314);
    bus_write(5'h09, 8'hfe);
    read_chk("R2 prelen masked", 5'h09, 8'h02);
    bus_write(5'h1a, 8'he3);
    chk("R2 mcast0 out", cfg_mcast0, 8'he3);
    bus_write(5'h00, 8'h55);
    read_chk("R2 version read-only", 5'h00, 8'h0e);
    @(negedge clk); sel = 0; wr = 1; addr = 5'h04; wdata = 8'h77;
    @(negedge clk); wr = 0;
    read_chk("R2 write without sel", 5'h04, 8'h0a);
  endtask

  task automatic t_mode;
    chk("R3 default arb", cfg_mode, 2'd1);
    bus_write(5'h02, 8'h20); chk("R3 break-sync", cfg_mode, 2'd2);
    bus_write(5'h02, 8'h40); chk("R3 full duplex", cfg_mode, 2'd3);
    bus_write(5'h02, 8'h00); chk("R3 half duplex", cfg_mode, 2'd0);
    bus_write(5'h02, 8'hff);
    chk("R3 two bits set", cfg_mode, 2'd0);
    read_chk("R2 setting bit7", 5'h02, 8'h7f);
  endtask

  task automatic t_sticky;
    @(negedge clk); ev_collide = 1;
    @(negedge clk); ev_collide = 0;
    repeat (3) @(negedge clk);
    read_chk("R4 collision sticky", 5'h10, 8'h40);
    read_chk("R5 cleared by read", 5'h10, 8'h00);
    @(negedge clk); ev_tx_err = 1; ev_rx_lost = 1;
    @(negedge clk); ev_tx_err = 0; ev_rx_lost = 0;
    read_chk("R4 tx err + lost", 5'h10, 8'h88);
    read_chk("R5 cleared again", 5'h10, 8'h00);
  endtask

  task automatic t_live;
    @(negedge clk); st_idle = 1; st_rx_ready = 1; st_tx_free = 1;
    read_chk("R6 live bits", 5'h10, 8'h23);
    read_chk("R6 live after read", 5'h10, 8'h23);
    @(negedge clk); st_idle = 0; st_rx_ready = 0; st_tx_free = 0;
    read_chk("R6 live follow low", 5'h10, 8'h00);
  endtask

  task automatic t_race;
    logic [7:0] v;
    @(negedge clk); ev_rx_broken = 1;
    @(negedge clk); ev_rx_broken = 0;
    @(negedge clk);
    sel = 1; rd = 1; addr = 5'h10; ev_brk_seen = 1;
    #1 v = rdata;
    @(posedge clk);
    @(negedge clk);
    sel = 0; rd = 0; ev_brk_seen = 0;
    chk("R5 pre-clear value", v, 8'h10);
    read_chk("R7 racing event kept", 5'h10, 8'h04);
    read_chk("R7 then cleared", 5'h10, 8'h00);
  endtask

  task automatic t_irq;
    bus_write(5'h11, 8'h02);
    read_chk("R8 mask readback", 5'h11, 8'h02);
    @(negedge clk); st_rx_ready = 1; #1 chk("R8 irq on live", irq, 1);
    @(negedge clk); st_rx_ready = 0; #1 chk("R8 irq off live", irq, 0);
    bus_write(5'h11, 8'h40);
    @(negedge clk); ev_collide = 1;
    @(negedge clk); ev_collide = 0; chk("R8 irq on sticky", irq, 1);
    @(negedge clk); ev_rx_lost = 1;
    @(negedge clk); ev_rx_lost = 0;
    bus_write(5'h11, 8'h00);
    chk("R8 irq masked off", irq, 0);
    bus_write(5'h11, 8'h40);
    chk("R8 irq unmasked", irq, 1);
    read_chk("R5 flags 0x48", 5'h10, 8'h48);
    chk("R8 irq after clear", irq, 0);
  endtask

  task automatic t_cmd;
    bus_write(5'h16, 8'h13);
    chk("R9 rx pulses", {cmd_rx_reset, cmd_rx_switch, cmd_rx_rewind}, 3'b111);
    chk("R9 no tx pulse", {cmd_tx_break, cmd_tx_abort, cmd_tx_switch, cmd_tx_rewind}, 4'b0);
    @(negedge clk);
    chk("R9 one cycle", {cmd_rx_reset, cmd_rx_switch, cmd_rx_rewind}, 3'b000);
    bus_write(5'h16, 8'h02);
    chk("R9 switch only", {cmd_rx_reset, cmd_rx_switch, cmd_rx_rewind}, 3'b010);
    read_chk("R9 read zero", 5'h16, 8'h00);
    bus_write(5'h17, 8'h33);
    chk("R10 tx pulses", {cmd_tx_break, cmd_tx_abort, cmd_tx_switch, cmd_tx_rewind}, 4'b1111);
    chk("R10 no rx pulse", {cmd_rx_reset, cmd_rx_switch, cmd_rx_rewind}, 3'b0);
    @(negedge clk);
    chk("R10 one cycle", {cmd_tx_break, cmd_tx_abort, cmd_tx_switch, cmd_tx_rewind}, 4'b0);
    bus_write(5'h17, 8'h20);
    chk("R10 break only", {cmd_tx_break, cmd_tx_abort, cmd_tx_switch, cmd_tx_rewind}, 4'b1000);
    read_chk("R10 read zero", 5'h17, 8'h00);
  endtask

  task automatic t_data;
    @(negedge clk);
    rx_port_data = 8'ha5; sel = 1; rd = 1; addr = 5'h14;
    #1 chk("R11 rx data", rdata, 8'ha5); chk("R11 rx pop", rx_pop, 1);
    @(negedge clk);
    rx_port_data = 8'h5c;
    #1 chk("R11 burst rx data", rdata, 8'h5c); chk("R11 burst pop", rx_pop, 1);
    @(negedge clk); sel = 0; rd = 0;
    #1 chk("R11 pop idle", rx_pop, 0);
    @(negedge clk); sel = 1; wr = 1; addr = 5'h15; wdata = 8'h3c;
    #1 chk("R11 tx push", tx_push, 1); chk("R11 tx data", tx_push_data, 8'h3c);
    @(negedge clk); sel = 0; wr = 0;
    #1 chk("R11 push idle", tx_push, 0);
  endtask

  task automatic t_unmapped;
    read_chk("R12 addr 0x03", 5'h03, 8'h00);
    read_chk("R12 addr 0x1f", 5'h1f, 8'h00);
    read_chk("R12 addr 0x18", 5'h18, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_config();
    t_mode();
    t_sticky();
    t_live();
    t_race();
    t_irq();
    t_cmd();
    t_data();
    t_unmapped();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule